// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Unit

This unit sits beside a simple processor core and decides, at each instruction boundary, whether the core must leave its current flow for an exception. Three sources are watched. The first is a reset request. The second is a non-maskable request. The third is a three-bit pending priority level supplied by an external interrupt controller. The unit compares the pending level with the core's status word, which holds an enable bit and a three-bit level mask. When an entry is taken, the unit issues one redirect carrying the new program counter, the updated status word and the lowered stack pointer. For stack-saving entries it also issues two stack write requests, one for the old program counter and one for the old status word.

Maskable entries are vectored. The new program counter is a fixed base plus a 16-bit offset chosen by the accepted level. The seven offsets live in a small bus-mapped register file that software can write. A maskable request is not consumed when it is served. It stays pending for as long as the controller keeps presenting that level. After issuing a redirect, the unit waits for the core to report that the redirect is complete before it evaluates another request.

Top module: `irq_accept_unit`

## Requirements
- R1: When several requests are pending at a boundary, a reset request wins over a non-maskable request, and a non-maskable request wins over a maskable level. Exactly one entry is issued per boundary.
- R2: A maskable level is taken only when status bit 11 (enable) is 1 and the pending level is numerically below the mask held in status bits 10:8.
- R3: A non-maskable entry does the following. It sets the redirect PC to 0x40000008. It clears the enable bit and leaves the other status bits unchanged. It sets the redirect SP to SP-8. It requests a 32-bit write of the old PC to SP-4 and a 16-bit write of the old status word to SP-8.
- R4: A maskable entry produces the same stack writes and the same SP-8 as a non-maskable entry. It clears the enable bit, replaces status bits 10:8 with the accepted level, and sets the redirect PC to 0x40000000 plus the zero-extended vector register of that level.
- R5: The acknowledge strobe pulses for one cycle, carrying the accepted level, on every maskable entry and on no other entry.
- R6: A non-maskable request is held in a sticky flag until its entry is issued. A maskable level is sampled every cycle, is not cleared by acceptance, and is served again at the next boundary while it remains pending.
- R7: After reset the stored pending level is 7, which means nothing is pending. The vector registers, the sticky flags and the two mode registers read zero, and no redirect is issued.
- R8: Bus reads return vector register n at byte offset 4n for n = 0 to 6, the memory-control register at offset 0x20 and the CPU-mode register at offset 0x40. Every other offset reads zero. Data is 16 bits, low byte in bits 7:0.
- R9: A write changes a vector register only when it is a 2-byte access to that register's offset. Writes of any other width, and writes to any other offset (including 0x20 and 0x40), change nothing.
- R10: A redirect output lasts one cycle and appears the cycle after the boundary strobe. Once it has been issued, boundaries are ignored until the redirect-done input has been seen.
- R11: A reset entry sets the redirect PC to 0x40000000, sets the status word to 0 and leaves SP unchanged. It issues no stack writes and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_req | input | 1 | Reset request pulse, latched |
| nmi_req | input | 1 | Non-maskable request pulse, latched |
| lvl_in | input | 3 | Pending maskable level from the controller (7 = none) |
| boundary | input | 1 | Instruction boundary strobe from the core |
| redir_done | input | 1 | Core reports that the last redirect has completed |
| pc_cur | input | 32 | Current program counter |
| sr_cur | input | 16 | Current status word |
| sp_cur | input | 32 | Current stack pointer |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_two | input | 1 | Access is 2 bytes wide |
| bus_addr | input | 7 | Byte offset within the register block |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| redir_vld | output | 1 | Redirect strobe |
| redir_pc | output | 32 | New program counter |
| redir_sr | output | 16 | New status word |
| redir_sp | output | 32 | New stack pointer |
| push_vld | output | 1 | Stack write requests valid |
| push_pc_addr | output | 32 | Address for the saved PC word |
| push_pc_data | output | 32 | Saved PC |
| push_sr_addr | output | 32 | Address for the saved status half-word |
| push_sr_data | output | 16 | Saved status word |
| ack_vld | output | 1 | Acknowledge strobe |
| ack_lvl | output | 3 | Accepted level |

## Verification
Two pairs of events can coincide, and the bench provokes both. In the first, a non-maskable entry and an open maskable level meet at the same boundary. The bench pends a reset, a non-maskable request and level 2 together. It then expects a reset redirect, then a non-maskable redirect, and only after that the level 2 entry with its acknowledge, re-served on later boundaries. In the second, a new request pulse or a boundary strobe falls in the same cycle as an entry that clears a flag, or in the same cycle as the done report. Random stimulus produces these overlaps often. Each cycle is judged against a bench model in which a new pulse outranks a clear and a done report reopens evaluation only from the following cycle.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
   typedef enum logic [1:0] {
      ENT_NONE  = 2'd0,
      ENT_RESET = 2'd1,
      ENT_NMI   = 2'd2,
      ENT_LEVEL = 2'd3
   } entry_e;
endpackage

// File: rtl/irqa_req_track.sv
module irqa_req_track #(
   parameter int LVLW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rst_req,
   input  logic            nmi_req,
   input  logic [LVLW-1:0] lvl_in,
   input  logic            clr_rst,
   input  logic            clr_nmi,
   output logic            rst_flag,
   output logic            nmi_flag,
   output logic [LVLW-1:0] pend_lvl
);
   localparam logic [LVLW-1:0] LVL_IDLE = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rst_flag <= 1'b0;
         nmi_flag <= 1'b0;
         pend_lvl <= LVL_IDLE;
      end else begin
         // a fresh pulse outranks the clear from a taken entry
         rst_flag <= rst_req | (rst_flag & ~clr_rst);
         nmi_flag <= nmi_req | (nmi_flag & ~clr_nmi);
         pend_lvl <= lvl_in;
      end
   end
endmodule

// File: rtl/irqa_pick.sv
module irqa_pick
   import irqa_pkg::*;
#(
   parameter int SRW    = 16,
   parameter int LVLW   = 3,
   parameter int IE_BIT = 11,
   parameter int LM_LSB = 8
) (
   input  logic            en,
   input  logic            rst_flag,
   input  logic            nmi_flag,
   input  logic [LVLW-1:0] pend_lvl,
   input  logic [SRW-1:0]  sr_cur,
   output entry_e          kind
);
   logic lvl_open;

   always_comb begin
      lvl_open = sr_cur[IE_BIT] && (pend_lvl < sr_cur[LM_LSB +: LVLW]);
      kind     = ENT_NONE;
      if (en) begin
         if (rst_flag)      kind = ENT_RESET;
         else if (nmi_flag) kind = ENT_NMI;
         else if (lvl_open) kind = ENT_LEVEL;
      end
   end
endmodule

// File: rtl/irqa_vec_regs.sv
module irqa_vec_regs #(
   parameter int          NVEC       = 7,
   parameter int          DW         = 16,
   parameter int          AW         = 7,
   parameter int          SELW       = 3,
   parameter int          STRIDE     = 4,
   parameter int          MEMCTL_OFF = 32,
   parameter int          MODE_OFF   = 64,
   parameter logic [15:0] MEMCTL_RST = 16'h0000,
   parameter logic [15:0] MODE_RST   = 16'h0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic            bus_two,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [SELW-1:0] vec_idx,
   output logic [DW-1:0]   vec_out
);
   localparam logic [AW-1:0] MEMCTL_A = AW'(MEMCTL_OFF);
   localparam logic [AW-1:0] MODE_A   = AW'(MODE_OFF);

   logic [NVEC*DW-1:0] vec_all;
   logic [DW-1:0]      memctl_q, mode_q;
   logic               wr_ok;

   assign wr_ok = bus_sel & bus_wr & bus_two;

   for (genvar g = 0; g < NVEC; g++) begin : g_vec
      localparam logic [AW-1:0] MY_A = AW'(g * STRIDE);
      logic [DW-1:0] r_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                         r_q <= '0;
         else if (wr_ok && bus_addr == MY_A) r_q <= bus_wdata;
      end
      assign vec_all[g*DW +: DW] = r_q;
   end

   // read-only control words, restored on reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         memctl_q <= DW'(MEMCTL_RST);
         mode_q   <= DW'(MODE_RST);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         for (int i = 0; i < NVEC; i++)
            if (bus_addr == AW'(i * STRIDE)) bus_rdata = vec_all[i*DW +: DW];
         if (bus_addr == MEMCTL_A) bus_rdata = memctl_q;
         if (bus_addr == MODE_A)   bus_rdata = mode_q;
      end
   end

   always_comb begin
      vec_out = '0;
      for (int i = 0; i < NVEC; i++)
         if (vec_idx == SELW'(i)) vec_out = vec_all[i*DW +: DW];
   end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import irqa_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          SRW      = 16,
   parameter int          LVLW     = 3,
   parameter int          NVEC     = 7,
   parameter int          VDW      = 16,
   parameter int          AW       = 7,
   parameter int          IE_BIT   = 11,
   parameter int          LM_LSB   = 8,
   parameter int          STRIDE   = 4,
   parameter int          FRAME    = 8,
   parameter logic [31:0] VEC_BASE = 32'h4000_0000,
   parameter logic [31:0] NMI_PC   = 32'h4000_0008,
   parameter logic [31:0] RESET_PC = 32'h4000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rst_req,
   input  logic            nmi_req,
   input  logic [LVLW-1:0] lvl_in,
   input  logic            boundary,
   input  logic            redir_done,
   input  logic [XLEN-1:0] pc_cur,
   input  logic [SRW-1:0]  sr_cur,
   input  logic [XLEN-1:0] sp_cur,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic            bus_two,
   input  logic [AW-1:0]   bus_addr,
   input  logic [VDW-1:0]  bus_wdata,
   output logic [VDW-1:0]  bus_rdata,
   output logic            redir_vld,
   output logic [XLEN-1:0] redir_pc,
   output logic [SRW-1:0]  redir_sr,
   output logic [XLEN-1:0] redir_sp,
   output logic            push_vld,
   output logic [XLEN-1:0] push_pc_addr,
   output logic [XLEN-1:0] push_pc_data,
   output logic [XLEN-1:0] push_sr_addr,
   output logic [SRW-1:0]  push_sr_data,
   output logic            ack_vld,
   output logic [LVLW-1:0] ack_lvl
);
   localparam logic [SRW-1:0]  IE_MASK = SRW'(1) << IE_BIT;
   localparam logic [SRW-1:0]  LM_MASK = SRW'((1 << LVLW) - 1) << LM_LSB;
   localparam logic [XLEN-1:0] HALF_FR = XLEN'(FRAME / 2);
   localparam logic [XLEN-1:0] FULL_FR = XLEN'(FRAME);

   if (NVEC != (1 << LVLW) - 1) begin : g_bad_nvec
      $error("NVEC must equal 2**LVLW-1");
   end
   if (LM_LSB + LVLW > SRW) begin : g_bad_lm
      $error("level mask field exceeds status width");
   end
   if (IE_BIT >= LM_LSB && IE_BIT < LM_LSB + LVLW) begin : g_bad_ie
      $error("enable bit overlaps level mask field");
   end
   if (NVEC * STRIDE > 32 || (1 << AW) <= 64) begin : g_bad_map
      $error("register map does not fit the address width");
   end

   logic            busy_q, take;
   logic            rst_flag, nmi_flag;
   logic [LVLW-1:0] pend_lvl;
   logic [VDW-1:0]  vec_sel;
   entry_e          kind;

   assign take = boundary & ~busy_q;

   irqa_req_track #(.LVLW(LVLW)) req_i (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
      .lvl_in(lvl_in), .clr_rst(kind == ENT_RESET), .clr_nmi(kind == ENT_NMI),
      .rst_flag(rst_flag), .nmi_flag(nmi_flag), .pend_lvl(pend_lvl)
   );

   irqa_pick #(.SRW(SRW), .LVLW(LVLW), .IE_BIT(IE_BIT), .LM_LSB(LM_LSB)) pick_i (
      .en(take), .rst_flag(rst_flag), .nmi_flag(nmi_flag),
      .pend_lvl(pend_lvl), .sr_cur(sr_cur), .kind(kind)
   );

   irqa_vec_regs #(.NVEC(NVEC), .DW(VDW), .AW(AW), .SELW(LVLW), .STRIDE(STRIDE)) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_two(bus_two), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .vec_idx(pend_lvl), .vec_out(vec_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         redir_vld    <= 1'b0;
         push_vld     <= 1'b0;
         ack_vld      <= 1'b0;
         redir_pc     <= '0;
         redir_sr     <= '0;
         redir_sp     <= '0;
         push_pc_addr <= '0;
         push_pc_data <= '0;
         push_sr_addr <= '0;
         push_sr_data <= '0;
         ack_lvl      <= '1;
      end else begin
         redir_vld <= 1'b0;
         push_vld  <= 1'b0;
         ack_vld   <= 1'b0;
         if (kind != ENT_NONE)   busy_q <= 1'b1;
         else if (redir_done)    busy_q <= 1'b0;
         if (kind == ENT_NMI || kind == ENT_LEVEL) begin
            push_vld     <= 1'b1;
            redir_sp     <= sp_cur - FULL_FR;
            push_pc_addr <= sp_cur - HALF_FR;
            push_pc_data <= pc_cur;
            push_sr_addr <= sp_cur - FULL_FR;
            push_sr_data <= sr_cur;
         end
         case (kind)
            ENT_RESET: begin
               redir_vld <= 1'b1;
               redir_pc  <= XLEN'(RESET_PC);
               redir_sr  <= '0;
               redir_sp  <= sp_cur;
            end
            ENT_NMI: begin
               redir_vld <= 1'b1;
               redir_pc  <= XLEN'(NMI_PC);
               redir_sr  <= sr_cur & ~IE_MASK;
            end
            ENT_LEVEL: begin
               redir_vld <= 1'b1;
               redir_pc  <= XLEN'(VEC_BASE) + XLEN'(vec_sel);
               redir_sr  <= (sr_cur & ~IE_MASK & ~LM_MASK)
                            | (SRW'(pend_lvl) << LM_LSB);
               ack_vld   <= 1'b1;
               ack_lvl   <= pend_lvl;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/irqa_checker.sv
module irqa_checker #(
   parameter int          SRW      = 16,
   parameter int          LVLW     = 3,
   parameter int          IE_BIT   = 11,
   parameter int          LM_LSB   = 8,
   parameter logic [31:0] RESET_PC = 32'h4000_0000
) (
   input logic            clk,
   input logic            rst_n,
   input logic            redir_vld,
   input logic            redir_done,
   input logic            push_vld,
   input logic            ack_vld,
   input logic [LVLW-1:0] ack_lvl,
   input logic [SRW-1:0]  redir_sr,
   input logic [31:0]     redir_pc,
   input logic [31:0]     redir_sp,
   input logic [31:0]     push_pc_addr,
   input logic [31:0]     push_sr_addr
);
   logic outst;

   always_ff @(posedge clk) begin
      if (!rst_n)                       outst <= 1'b0;
      else if (redir_vld && !redir_done) outst <= 1'b1;
      else if (redir_done)              outst <= 1'b0;
   end

   AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |-> !outst); // R10
   AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |=> !redir_vld); // R10
   AST_ACK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> (redir_vld && push_vld)); // R5
   AST_ACK_LVL_SR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> (redir_sr[LM_LSB +: LVLW] == ack_lvl)); // R4
   AST_IE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      redir_vld |-> !redir_sr[IE_BIT]); // R3
   AST_FRAME_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      push_vld |-> (redir_sp == push_sr_addr && push_pc_addr == push_sr_addr + 32'd4)); // R3
   AST_PUSH_IN_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
      push_vld |-> redir_vld); // R11
   AST_RESET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_vld && !push_vld) |-> (redir_pc == RESET_PC && redir_sr == '0)); // R11
endmodule

bind irq_accept_unit irqa_checker #(
   .SRW(SRW), .LVLW(LVLW), .IE_BIT(IE_BIT), .LM_LSB(LM_LSB), .RESET_PC(RESET_PC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .redir_vld(redir_vld), .redir_done(redir_done),
   .push_vld(push_vld), .ack_vld(ack_vld), .ack_lvl(ack_lvl), .redir_sr(redir_sr),
   .redir_pc(redir_pc), .redir_sp(redir_sp), .push_pc_addr(push_pc_addr),
   .push_sr_addr(push_sr_addr)
);

// File: tb/irq_accept_unit_tb_top.sv
`timescale 1ns/1ps
module irq_accept_unit_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, rst_req, nmi_req, boundary, redir_done;
   logic [2:0]  lvl_in;
   logic [31:0] pc_cur, sp_cur;
   logic [15:0] sr_cur;
   logic        bus_sel, bus_wr, bus_two;
   logic [6:0]  bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic        redir_vld, push_vld, ack_vld;
   logic [31:0] redir_pc, redir_sp, push_pc_addr, push_pc_data, push_sr_addr;
   logic [15:0] redir_sr, push_sr_data;
   logic [2:0]  ack_lvl;

   irq_accept_unit dut_i (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
      .lvl_in(lvl_in), .boundary(boundary), .redir_done(redir_done),
      .pc_cur(pc_cur), .sr_cur(sr_cur), .sp_cur(sp_cur),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_two(bus_two),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .redir_vld(redir_vld), .redir_pc(redir_pc), .redir_sr(redir_sr),
      .redir_sp(redir_sp), .push_vld(push_vld), .push_pc_addr(push_pc_addr),
      .push_pc_data(push_pc_data), .push_sr_addr(push_sr_addr),
      .push_sr_data(push_sr_data), .ack_vld(ack_vld), .ack_lvl(ack_lvl)
   );

   int n_chk = 0, n_fail = 0;
   bit m_rst, m_nmi, m_busy;
   logic [2:0]  m_lvl;
   logic [15:0] m_vec [7];

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(logic [6:0] a);
      for (int i = 0; i < 7; i++) if (a == 7'(i * 4)) return m_vec[i];
      return 16'h0000; // 0x20, 0x40 read zero after reset, unmapped reads zero
   endfunction

   // 0 none, 1 reset, 2 nmi, 3 level
   function automatic int exp_kind();
      if (!boundary || m_busy) return 0;
      if (m_rst) return 1;
      if (m_nmi) return 2;
      if (sr_cur[11] && m_lvl < sr_cur[10:8]) return 3;
      return 0;
   endfunction

   task automatic idle();
      rst_req = 0; nmi_req = 0; boundary = 0; redir_done = 0;
      bus_sel = 0; bus_wr = 0; bus_two = 1; bus_addr = '0; bus_wdata = '0;
   endtask

   // called right after inputs are driven at a falling edge
   task automatic cyc(string tag);
      int k;
      logic [31:0] e_pc, e_sp;
      logic [15:0] e_sr;
      string rq;
      #1;
      if (bus_sel && !bus_wr)
         chk(bus_rdata == exp_read(bus_addr), {tag, " R8 read"}, 32'(bus_rdata), 32'(exp_read(bus_addr)));
      k = exp_kind();
      e_sp = sp_cur - 32'd8;
      e_sr = sr_cur & ~16'h0800;
      e_pc = 32'h4000_0008;
      rq = "R2 R10 no entry";
      if (k == 1) begin e_pc = 32'h4000_0000; e_sr = '0; e_sp = sp_cur; rq = "R1 R11 reset entry"; end
      if (k == 2) rq = "R1 R3 nmi entry";
      if (k == 3) begin
         e_sr = (sr_cur & ~16'h0F00) | (16'(m_lvl) << 8);
         e_pc = 32'h4000_0000 + 32'(m_vec[m_lvl]);
         rq = "R4 R5 level entry";
      end
      begin
         logic [31:0] spv, pcv, srv; logic [2:0] lv;
         spv = sp_cur; pcv = pc_cur; srv = 32'(sr_cur); lv = m_lvl;
         @(posedge clk); #1;
         rq = {tag, " ", rq};
         chk(redir_vld == (k != 0), rq, 32'(redir_vld), 32'(k != 0));
         chk(ack_vld == (k == 3), {rq, " ack"}, 32'(ack_vld), 32'(k == 3));
         chk(push_vld == (k >= 2), {rq, " push"}, 32'(push_vld), 32'(k >= 2));
         if (k != 0) begin
            chk(redir_pc == e_pc, {rq, " pc"}, redir_pc, e_pc);
            chk(redir_sr == e_sr, {rq, " sr"}, 32'(redir_sr), 32'(e_sr));
            chk(redir_sp == e_sp, {rq, " sp"}, redir_sp, e_sp);
         end
         if (k >= 2) begin
            chk(push_pc_addr == spv - 32'd4 && push_pc_data == pcv, {rq, " pc push"}, push_pc_addr, spv - 32'd4);
            chk(push_sr_addr == spv - 32'd8 && 32'(push_sr_data) == srv, {rq, " sr push"}, push_sr_addr, spv - 32'd8);
         end
         if (k == 3) chk(ack_lvl == lv, {rq, " ack level"}, 32'(ack_lvl), 32'(lv));
      end
      // model update with the inputs of the cycle just ended
      m_rst = rst_req | (m_rst & (k != 1));
      m_nmi = nmi_req | (m_nmi & (k != 2));
      m_lvl = lvl_in;
      if (k != 0) m_busy = 1; else if (redir_done) m_busy = 0;
      if (bus_sel && bus_wr && bus_two)
         for (int i = 0; i < 7; i++) if (bus_addr == 7'(i * 4)) m_vec[i] = bus_wdata;
      @(negedge clk);
   endtask

   task automatic wr(logic [6:0] a, logic [15:0] d, bit two, string tag);
      idle(); bus_sel = 1; bus_wr = 1; bus_two = two; bus_addr = a; bus_wdata = d;
      cyc(tag);
   endtask

   task automatic rd(logic [6:0] a, string tag);
      idle(); bus_sel = 1; bus_wr = 0; bus_addr = a;
      cyc(tag);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      idle();
      rst_n = 0; lvl_in = 3'd7; pc_cur = 32'h0000_1234; sp_cur = 32'h0000_8000; sr_cur = 16'h0F00;
      m_rst = 0; m_nmi = 0; m_busy = 0; m_lvl = 3'd7;
      for (int i = 0; i < 7; i++) m_vec[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R7: enabled status with mask 7, stored level 7, nothing taken
      chk(redir_vld == 0 && ack_vld == 0, "R7 outputs after reset", 32'(redir_vld), 0);
      idle(); boundary = 1; sr_cur = 16'h0F00; cyc("R7");
      for (int i = 0; i < 7; i++) rd(7'(i * 4), "R7 vector zero");
      rd(7'h20, "R7 memctl"); rd(7'h40, "R7 mode");
      // R9: programming and ignored writes
      for (int i = 0; i < 7; i++) wr(7'(i * 4), 16'h1000 + 16'(i * 16'h0111), 1, "R9");
      wr(7'h0C, 16'hDEAD, 0, "R9 narrow write");
      wr(7'h20, 16'hBEEF, 1, "R9 memctl write");
      wr(7'h40, 16'hBEEF, 1, "R9 mode write");
      wr(7'h1C, 16'hBEEF, 1, "R9 gap write");
      for (int i = 0; i < 8; i++) rd(7'(i * 4), "R9 readback");
      rd(7'h20, "R9 memctl"); rd(7'h40, "R9 mode"); rd(7'h02, "R8 odd offset");
      // R1: all three pending together
      idle(); rst_req = 1; nmi_req = 1; lvl_in = 3'd2; cyc("R1 arm");
      idle(); boundary = 1; cyc("R1 first");
      idle(); boundary = 1; cyc("R10 busy");
      idle(); redir_done = 1; cyc("R10 done");
      idle(); boundary = 1; sp_cur = 32'h0000_7FF0; cyc("R1 second");
      idle(); redir_done = 1; cyc("R10 done");
      idle(); boundary = 1; cyc("R1 third");
      idle(); redir_done = 1; cyc("R10 done");
      idle(); boundary = 1; sr_cur = 16'h0F00; cyc("R6 level stays");
      idle(); redir_done = 1; cyc("R10 done");
      // R2: masked cases
      idle(); boundary = 1; sr_cur = 16'h0A00; cyc("R2 equal mask");
      idle(); boundary = 1; sr_cur = 16'h0700; cyc("R2 disabled");
      idle(); lvl_in = 3'd7; cyc("R6 level drop");
      idle(); boundary = 1; sr_cur = 16'h0F00; cyc("R2 level seven");
      // random phase
      for (int n = 0; n < 6000; n++) begin
         idle();
         rst_req    = ($urandom_range(0, 59) == 0);
         nmi_req    = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 3) == 0) lvl_in = 3'($urandom_range(0, 7));
         boundary   = $urandom_range(0, 1);
         redir_done = ($urandom_range(0, 2) == 0);
         pc_cur     = $urandom();
         sp_cur     = $urandom();
         sr_cur     = 16'($urandom());
         if ($urandom_range(0, 2) == 0) begin
            bus_sel   = 1;
            bus_wr    = $urandom_range(0, 1);
            bus_two   = ($urandom_range(0, 3) != 0);
            bus_addr  = ($urandom_range(0, 3) == 0) ? 7'($urandom()) : 7'($urandom_range(0, 8) * 4);
            bus_wdata = 16'($urandom());
         end
         cyc("R6 R10 random");
      end
      summary();
      $finish;
   end
endmodule